// File: doc/BRIEF.md
# Interleaved Stream Image Selector

This block sits on a byte stream that carries several configuration images woven together in fixed-length chunks. The first chunk of the stream holds bytes of image 1, the next chunk holds bytes of image 2, and so on, wrapping back to image 1 after the last image. The block lets through only the bytes of one chosen image and silently consumes every other byte. Both sides use a valid/ready handshake, and a forwarded byte passes through in the same cycle with no storage.

Ownership is decided by a running position in the combined stream. It is kept as a position inside the current chunk plus the index of the current chunk modulo the image count, so no divider is needed. The image count and the selected image are captured while reset is held. Releasing reset restarts the position at the head of the combined stream.

Top module: `ilv_stream_pick`

## Requirements
- R1: While `rstN` is low the stream position is cleared, so the first byte consumed after reset is byte 0 of the stream and belongs to image 1.
- R2: Stream byte number p (counted from 0 since reset) belongs to image k (1-based) exactly when floor(p / CHUNK_LEN) mod N equals k-1, with CHUNK_LEN = 288 by default and N the captured image count.
- R3: A byte of the selected image is presented in the same cycle: `outValid` equals `inValid` and `outData` equals `inData`.
- R4: While a byte of the selected image is presented, `inReady` equals `outReady`.
- R5: A byte of any other image is dropped: `outValid` is 0 and `inReady` is 1, whatever `outReady` is.
- R6: `cfgError` is 1 when the captured selection is 0, the selection exceeds the image count, or the image count is 0 or above MAX_IMAGES (4 by default); while it is 1 every byte is dropped as in R5.
- R7: The stream position advances by one only in a cycle where `inValid` and `inReady` are both 1; idle and stalled cycles leave it unchanged.
- R8: `numImagesIn` and `selImageIn` are captured only while `rstN` is low; changing them after reset is released has no effect on which bytes are forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset; restarts the stream and captures the configuration |
| numImagesIn | input | IDX_W (3) | Number of interleaved images, captured during reset |
| selImageIn | input | IDX_W (3) | 1-based index of the image to forward, captured during reset |
| inValid | input | 1 | Input byte present |
| inData | input | DATA_W (8) | Input byte |
| inReady | output | 1 | Input byte accepted this cycle when high together with `inValid` |
| outValid | output | 1 | Output byte present |
| outData | output | DATA_W (8) | Output byte |
| outReady | input | 1 | Downstream accepts the output byte |
| cfgError | output | 1 | Captured configuration is invalid |

## Verification
The selector is driven with long runs that cross several chunk boundaries and the full image-rotation wrap, for image counts 1, 2 and 3 and for the first, middle and last image, so an off-by-one in the chunk length, in the rotation wrap or in the 1-based selection shows up as a misplaced byte. Downstream back-pressure is applied always-ready, alternating and in an irregular pattern, which separates a design that advances the position on a stalled selected byte from one that holds it. Input gaps check that idle cycles do not move the position, and invalid selections check that nothing leaks out while the error flag is raised. Every run changes the configuration inputs right after reset, and one run restarts mid-stream, to show that capture and restart happen only in reset.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCfg;   // capture configuration and clear position
    logic advance;   // one byte consumed
  } ilv_strobe_t;

endpackage

// File: rtl/ilv_datapath.sv
module ilv_datapath
  import ilv_pkg::*;
#(
  parameter int CHUNK_LEN  = 288,
  parameter int MAX_IMAGES = 4,
  parameter int IDX_W      = $clog2(MAX_IMAGES + 1),
  parameter int CNT_W      = (CHUNK_LEN > 1) ? $clog2(CHUNK_LEN) : 1
) (
  input  logic             clk,
  input  ilv_strobe_t      strobe,
  input  logic [IDX_W-1:0] numImagesIn,
  input  logic [IDX_W-1:0] selImageIn,
  output logic [CNT_W-1:0] byteCnt,
  output logic [IDX_W-1:0] chunkIdx,
  output logic [IDX_W-1:0] selReg,
  output logic             errReg
);

  localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(CHUNK_LEN - 1);
  localparam logic [IDX_W-1:0] MAX_IDX   = IDX_W'(MAX_IMAGES);

  logic [IDX_W-1:0] numReg;
  logic             cfgBad;
  logic             chunkEnd;
  logic             lastChunk;

  assign cfgBad = (selImageIn == '0) || (numImagesIn == '0) ||
                  (selImageIn > numImagesIn) || (numImagesIn > MAX_IDX);

  assign chunkEnd  = (byteCnt == LAST_BYTE);
  assign lastChunk = (chunkIdx == numReg - 1'b1);

  always_ff @(posedge clk) begin
    if (strobe.loadCfg) begin
      numReg   <= numImagesIn;
      selReg   <= selImageIn;
      errReg   <= cfgBad;
      byteCnt  <= '0;
      chunkIdx <= '0;
    end else if (strobe.advance) begin
      if (chunkEnd) begin
        byteCnt  <= '0;
        chunkIdx <= lastChunk ? '0 : chunkIdx + 1'b1;
      end else begin
        byteCnt <= byteCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ilv_control.sv
module ilv_control
  import ilv_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             rstN,
  input  logic [IDX_W-1:0] chunkIdx,
  input  logic [IDX_W-1:0] selReg,
  input  logic             errReg,
  input  logic             inValid,
  input  logic             outReady,
  output logic             inReady,
  output logic             outValid,
  output ilv_strobe_t      strobe
);

  logic owned;

  assign owned    = !errReg && (chunkIdx == selReg - 1'b1);
  assign inReady  = owned ? outReady : 1'b1;
  assign outValid = rstN && owned && inValid;

  always_comb begin
    strobe         = '0;
    strobe.loadCfg = !rstN;
    strobe.advance = rstN && inValid && inReady;
  end

endmodule

// File: rtl/ilv_stream_pick.sv
module ilv_stream_pick
  import ilv_pkg::*;
#(
  parameter int CHUNK_LEN  = 288,
  parameter int MAX_IMAGES = 4,
  parameter int DATA_W     = 8,
  parameter int IDX_W      = $clog2(MAX_IMAGES + 1),
  parameter int CNT_W      = (CHUNK_LEN > 1) ? $clog2(CHUNK_LEN) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  numImagesIn,
  input  logic [IDX_W-1:0]  selImageIn,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  input  logic              outReady,
  output logic              cfgError
);

  ilv_strobe_t      strobe;
  logic [CNT_W-1:0] byteCnt;
  logic [IDX_W-1:0] chunkIdx;
  logic [IDX_W-1:0] selReg;
  logic             errReg;

  ilv_datapath #(
    .CHUNK_LEN (CHUNK_LEN),
    .MAX_IMAGES(MAX_IMAGES),
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W)
  ) u_dp (
    .clk        (clk),
    .strobe     (strobe),
    .numImagesIn(numImagesIn),
    .selImageIn (selImageIn),
    .byteCnt    (byteCnt),
    .chunkIdx   (chunkIdx),
    .selReg     (selReg),
    .errReg     (errReg)
  );

  ilv_control #(
    .IDX_W(IDX_W)
  ) u_ctl (
    .rstN    (rstN),
    .chunkIdx(chunkIdx),
    .selReg  (selReg),
    .errReg  (errReg),
    .inValid (inValid),
    .outReady(outReady),
    .inReady (inReady),
    .outValid(outValid),
    .strobe  (strobe)
  );

  assign outData  = inData;
  assign cfgError = errReg;

endmodule

// File: rtl/ilv_stream_pick_chk.sv
module ilv_stream_pick_chk #(
  parameter int CHUNK_LEN = 288,
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic [DATA_W-1:0] inData,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData,
  input logic              cfgError,
  input logic [CNT_W-1:0]  byteCnt
);

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt < CNT_W'(CHUNK_LEN)); // R2

  AST_CHUNK_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (byteCnt == CNT_W'(CHUNK_LEN - 1) && inValid && inReady) |=> byteCnt == '0); // R2

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (inValid && outData == inData)); // R3

  AST_READY_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (inReady == outReady)); // R4

  AST_DROP_READY: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !outValid) |-> inReady); // R5

  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> !outValid); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inReady) |=> $stable(byteCnt)); // R7

endmodule

bind ilv_stream_pick ilv_stream_pick_chk #(
  .CHUNK_LEN(CHUNK_LEN),
  .DATA_W   (DATA_W),
  .CNT_W    (CNT_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .inReady (inReady),
  .inData  (inData),
  .outValid(outValid),
  .outReady(outReady),
  .outData (outData),
  .cfgError(cfgError),
  .byteCnt (byteCnt)
);

// File: tb/ilv_stream_pick_bench.sv
module ilv_stream_pick_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CHUNK      = 288;
  localparam int IDX_W      = 3;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [IDX_W-1:0] numImagesIn = '0;
  logic [IDX_W-1:0] selImageIn = '0;
  logic             inValid = 1'b0;
  logic [7:0]       inData = '0;
  logic             inReady;
  logic             outValid;
  logic [7:0]       outData;
  logic             outReady = 1'b0;
  logic             cfgError;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ilv_stream_pick u_ilv_stream_pick (
    .clk        (clk),
    .rstN       (rstN),
    .numImagesIn(numImagesIn),
    .selImageIn (selImageIn),
    .inValid    (inValid),
    .inData     (inData),
    .inReady    (inReady),
    .outValid   (outValid),
    .outData    (outData),
    .outReady   (outReady),
    .cfgError   (cfgError)
  );

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expected, $time);
    end
  endtask

  // R8: configuration captured in reset, then the inputs are scrambled
  task automatic doReset(input int n, input int sel);
    @(negedge clk);
    rstN = 1'b0;
    inValid = 1'b0;
    numImagesIn = IDX_W'(n);
    selImageIn = IDX_W'(sel);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    numImagesIn = 3'd1;
    selImageIn = 3'd7;
  endtask

  function automatic bit readyFor(input int mode, input int i);
    case (mode)
      0: return 1'b1;
      1: return i[0];
      default: return (i % 3) != 0;
    endcase
  endfunction

  // Streams len cycles; checks R2..R7 each cycle against a model position
  task automatic runStream(input int n, input int sel, input int len,
                           input int rdyMode, input bit gaps, input bit expErr);
    int pos = 0;
    doReset(n, sel);
    #1;
    check(cfgError == expErr, "R6 error flag", cfgError, expErr);
    check(outValid == 1'b0, "R1 idle after reset", outValid, 0);
    for (int i = 0; i < len; i++) begin
      bit vld;
      bit rdy;
      bit own;
      @(negedge clk);
      vld = gaps ? ((i % 5) != 4) : 1'b1;
      rdy = readyFor(rdyMode, i);
      inValid = vld;
      inData = 8'(pos * 7 + 3);
      outReady = rdy;
      #1;
      own = !expErr && ((((pos / CHUNK) % n) + 1) == sel);
      if (!vld) begin
        check(outValid == 1'b0, "R7 idle no output", outValid, 0);
      end else if (own) begin
        check(outValid == 1'b1, "R2/R3 owned byte valid", outValid, 1);
        check(outData == 8'(pos * 7 + 3), "R3 data", outData, 8'(pos * 7 + 3));
        check(inReady == rdy, "R4 ready follows", inReady, rdy);
        if (rdy) pos++;
      end else begin
        check(outValid == 1'b0, "R5 dropped no output", outValid, 0);
        check(inReady == 1'b1, "R5 dropped ready", inReady, 1);
        pos++;
      end
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic testRestart();
    // R1: drop 100 bytes of image 1 while selecting image 2, then restart with image 1
    doReset(2, 2);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      inValid = 1'b1;
      inData = 8'hA5;
      outReady = 1'b1;
      #1;
      check(outValid == 1'b0, "R1 pre-restart drop", outValid, 0);
    end
    doReset(2, 1);
    inValid = 1'b1;
    inData = 8'h3C;
    outReady = 1'b1;
    #1;
    check(outValid == 1'b1, "R1 restart owner", outValid, 1);
    check(outData == 8'h3C, "R1 restart data", outData, 8'h3C);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    runStream(3, 1, 1000, 0, 1'b0, 1'b0);  // R2 first image, boundaries and wrap
    runStream(3, 3, 1800, 1, 1'b0, 1'b0);  // R4 last image, alternating ready
    runStream(2, 2, 1400, 2, 1'b1, 1'b0);  // R7 gaps, irregular ready
    runStream(1, 1, 700, 2, 1'b1, 1'b0);   // single image: all forwarded
    runStream(4, 2, 1300, 0, 1'b0, 1'b0);  // full image count
    runStream(3, 0, 400, 0, 1'b0, 1'b1);   // R6 selection zero
    runStream(3, 4, 400, 1, 1'b0, 1'b1);   // R6 selection above count
    runStream(5, 1, 300, 0, 1'b0, 1'b1);   // R6 count above maximum
    testRestart();                         // R1 R8
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule